// File: doc/BRIEF.md
# Receiver Lane Reset Sequencer

This block orders the two resets that a serial receiver lane needs when it comes up: an analog reset for the front end and a digital reset for the logic behind it. A reset request holds both resets active. Once the request is gone, the analog reset stays on for a set time. The digital reset then waits for the lane to report lock to the incoming data, and stays on for its own set time after that. Both times are given in nanoseconds together with the clock period. They are turned into whole clock cycles when the design is elaborated.

Loss of data lock after release can be handled in three ways, chosen by a parameter. In automatic mode the digital reset comes back on and its timer starts again. In manual mode the lane keeps running and recovery is left to user logic. In run-time mode an input pin chooses between those two behaviours. The block can run one controller per lane, or one controller for all lanes. In the shared case there is one request input, the lock inputs are ANDed into one status, and one pair of outputs is driven. A parameter can switch off the whole function, in which case all outputs stay inactive. The request, lock and manual-select inputs are asynchronous, and each passes through a two-stage synchronizer before it is used.

Top module: `rx_lane_reset_seq`

## Requirements
- R1: With `ENABLE` = 0, `analog_rst` and `digital_rst` are held at 0 whatever the inputs do.
- R2: A duration becomes ceil(ns / `CLK_NS`) cycles, with a minimum of one cycle (A for analog, D for digital). When `reset_req` falls at an input, the matching `analog_rst` goes low A+2 clock edges later.
- R3: With lock held high, `digital_rst` goes low A+D+3 edges after `reset_req` falls, and not earlier.
- R4: The digital hold period starts only after the analog reset is released and lock is high. If lock drops during the hold, the controller goes back to waiting, even in manual mode. Once lock returns, `digital_rst` goes low D+3 edges later.
- R5: In automatic mode (`LOCK_MODE` = `LOCK_AUTO`, encoded as 0), a fall of lock on a released lane raises `digital_rst` 3 edges later, and `analog_rst` stays low.
- R6: In manual mode (`LOCK_MODE` = `LOCK_MANUAL`, encoded as 1), loss of lock on a released lane leaves `digital_rst` low.
- R7: In run-time mode (`LOCK_MODE` = `LOCK_RUNTIME`, encoded as 2), `manual_sel` = 1 gives the manual behaviour and `manual_sel` = 0 gives the automatic one. After `manual_sel` falls while lock is low, `digital_rst` rises 3 edges later.
- R8: With `PER_LANE` = 1, bit i of `reset_req` and `lock_in` controls only bit i of the outputs.
- R9: With `PER_LANE` = 0, there is one request bit and one output pair, and the controller sees the AND of all `lock_in` bits.
- R10: A request at any phase restarts the sequence. Both resets are high 3 edges after `reset_req` rises, and the full A and D timing counts again from the request's fall.
- R11: After `rst_n` is released, both outputs are high while the request is held. `analog_rst` high always implies `digital_rst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, period `CLK_NS` ns |
| rst_n | input | 1 | Active-low reset of the sequencer registers |
| reset_req | input | UNITS | Asynchronous reset request, one bit per controller |
| lock_in | input | LANES | Asynchronous per-lane data-lock status |
| manual_sel | input | 1 | Run-time choice of manual (1) or automatic (0) lock handling |
| analog_rst | output | UNITS | Registered analog reset, active high |
| digital_rst | output | UNITS | Registered digital reset, active high |

## Verification
The bound checker watches, on every cycle and for every controller, the following rules:
- the analog reset never stands alone;
- a synchronized request always asserts both resets on the next cycle;
- the analog reset is released only when no request was seen;
- the digital reset is released only after lock was seen;
- in automatic mode, a low lock keeps the digital reset on;
- in manual mode, a running lane stays running.

The exact durations need the bench's timed scenarios, as do the end-to-end latency through the synchronizers, the independence of the lanes and the full sweep of ANDed lock patterns. The restart that happens in the middle of the hold also depends on those scenarios.

// File: rtl/rx_rst_pkg.sv
package rx_rst_pkg;

  typedef enum logic [1:0] {
    LOCK_AUTO    = 2'd0,
    LOCK_MANUAL  = 2'd1,
    LOCK_RUNTIME = 2'd2
  } lock_mode_e;

  typedef enum logic [1:0] {
    PH_ANALOG = 2'd0,
    PH_WAIT   = 2'd1,
    PH_HOLD   = 2'd2,
    PH_RUN    = 2'd3
  } phase_e;

  // ceiling of ns / period, never less than one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync #(
  parameter int unsigned W    = 1,
  parameter bit          INIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= {W{INIT}};
      q      <= {W{INIT}};
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rx_rst_ctrl.sv
module rx_rst_ctrl
  import rx_rst_pkg::*;
#(
  parameter int unsigned A_CYC = 5,
  parameter int unsigned D_CYC = 500,
  localparam int unsigned CW   = $clog2(max_u(A_CYC, D_CYC) + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic lock,
  input  logic manual,
  output logic ana_rst,
  output logic dig_rst
);
  localparam logic [CW-1:0] A_LAST = CW'(A_CYC - 1);
  localparam logic [CW-1:0] D_LAST = CW'(D_CYC - 1);

  phase_e        ph, ph_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    ph_n  = ph;
    cnt_n = cnt;
    if (req) begin
      ph_n  = PH_ANALOG;
      cnt_n = '0;
    end else begin
      unique case (ph)
        PH_ANALOG: begin
          if (cnt == A_LAST) begin
            ph_n  = PH_WAIT;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        PH_WAIT: begin
          if (lock) begin
            ph_n  = PH_HOLD;
            cnt_n = '0;
          end
        end
        PH_HOLD: begin
          if (!lock)                ph_n  = PH_WAIT;
          else if (cnt == D_LAST)   ph_n  = PH_RUN;
          else                      cnt_n = cnt + 1'b1;
        end
        PH_RUN: begin
          if (!lock && !manual) ph_n = PH_WAIT;
        end
        default: ph_n = PH_ANALOG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_ANALOG;
      cnt     <= '0;
      ana_rst <= 1'b1;
      dig_rst <= 1'b1;
    end else begin
      ph      <= ph_n;
      cnt     <= cnt_n;
      ana_rst <= (ph_n == PH_ANALOG);
      dig_rst <= (ph_n != PH_RUN);
    end
  end
endmodule

// File: rtl/rx_lane_reset_seq.sv
module rx_lane_reset_seq
  import rx_rst_pkg::*;
#(
  parameter int unsigned LANES      = 2,
  parameter bit          PER_LANE   = 1'b1,
  parameter bit          ENABLE     = 1'b1,
  parameter lock_mode_e  LOCK_MODE  = LOCK_AUTO,
  parameter int unsigned CLK_NS     = 8,
  parameter int unsigned ANALOG_NS  = 40,
  parameter int unsigned DIGITAL_NS = 4000,
  localparam int unsigned UNITS     = PER_LANE ? LANES : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [UNITS-1:0] reset_req,
  input  logic [LANES-1:0] lock_in,
  input  logic             manual_sel,
  output logic [UNITS-1:0] analog_rst,
  output logic [UNITS-1:0] digital_rst
);
  localparam int unsigned A_CYC = ns_to_cycles(ANALOG_NS, CLK_NS);
  localparam int unsigned D_CYC = ns_to_cycles(DIGITAL_NS, CLK_NS);

  // named internal events, observed by the bound checker
  logic [UNITS-1:0] req_s;
  logic [LANES-1:0] lane_lock_s;
  logic [UNITS-1:0] unit_lock;
  logic [UNITS-1:0] unit_manual;
  logic             man_s;

  if (ENABLE) begin : g_on
    rx_rst_sync #(.W(UNITS), .INIT(1'b1)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(reset_req), .q(req_s));
    rx_rst_sync #(.W(LANES), .INIT(1'b0)) u_lock_sync (
      .clk(clk), .rst_n(rst_n), .d(lock_in), .q(lane_lock_s));
    rx_rst_sync #(.W(1), .INIT(1'b0)) u_man_sync (
      .clk(clk), .rst_n(rst_n), .d(manual_sel), .q(man_s));

    if (PER_LANE) begin : g_lane_lock
      assign unit_lock = lane_lock_s;
    end else begin : g_and_lock
      assign unit_lock = &lane_lock_s;
    end

    logic manual_eff;
    assign manual_eff = (LOCK_MODE == LOCK_MANUAL) ||
                        ((LOCK_MODE == LOCK_RUNTIME) && man_s);
    assign unit_manual = {UNITS{manual_eff}};

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
      rx_rst_ctrl #(.A_CYC(A_CYC), .D_CYC(D_CYC)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_s[u]),
        .lock   (unit_lock[u]),
        .manual (unit_manual[u]),
        .ana_rst(analog_rst[u]),
        .dig_rst(digital_rst[u])
      );
    end
  end else begin : g_off
    logic unused_inputs;
    assign unused_inputs = ^{reset_req, lock_in, manual_sel, clk, rst_n};
    assign req_s        = '0;
    assign lane_lock_s  = '0;
    assign unit_lock    = '0;
    assign unit_manual  = '0;
    assign man_s        = 1'b0;
    assign analog_rst   = '0;
    assign digital_rst  = '0;
  end
endmodule

// File: rtl/rx_lane_reset_seq_chk.sv
module rx_lane_reset_seq_chk #(
  parameter int unsigned UNITS  = 1,
  parameter bit          ENABLE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [UNITS-1:0] req_s,
  input logic [UNITS-1:0] unit_lock,
  input logic [UNITS-1:0] unit_manual,
  input logic [UNITS-1:0] analog_rst,
  input logic [UNITS-1:0] digital_rst
);
  if (!ENABLE) begin : g_off
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (analog_rst == '0) && (digital_rst == '0));
  end else begin : g_on
    for (genvar i = 0; i < UNITS; i++) begin : g_u
      assert_analog_implies_digital_R11: assert property (@(posedge clk) disable iff (!rst_n)
        analog_rst[i] |-> digital_rst[i]);
      assert_request_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_s[i] |=> (analog_rst[i] && digital_rst[i]));
      assert_analog_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(analog_rst[i]) |-> !$past(req_s[i]));
      assert_release_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(digital_rst[i]) |-> $past(unit_lock[i]));
      assert_auto_reasserts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_lock[i] && !unit_manual[i]) |=> digital_rst[i]);
      assert_manual_keeps_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!digital_rst[i] && unit_manual[i] && !req_s[i]) |=> !digital_rst[i]);
    end
  end
endmodule

bind rx_lane_reset_seq rx_lane_reset_seq_chk #(.UNITS(UNITS), .ENABLE(ENABLE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_s      (req_s),
  .unit_lock  (unit_lock),
  .unit_manual(unit_manual),
  .analog_rst (analog_rst),
  .digital_rst(digital_rst)
);

// File: tb/sim_rx_lane_reset_seq.sv
`timescale 1ns/1ps
module sim_rx_lane_reset_seq;
  import rx_rst_pkg::*;

  localparam int unsigned PER = 8;
  localparam int unsigned ANS = 20;
  localparam int unsigned DNS = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // u0: per-lane, run-time mode; u1: shared 3 lanes auto; u2: shared manual; u3: disabled
  logic [1:0] req0, lock0, ana0, dig0;
  logic       man0;
  logic [0:0] req1, ana1, dig1;
  logic [2:0] lock1;
  logic [0:0] req2, ana2, dig2;
  logic [1:0] lock2;
  logic [1:0] req3, lock3, ana3, dig3;
  logic       man3;

  rx_lane_reset_seq #(.LANES(2), .PER_LANE(1'b1), .ENABLE(1'b1), .LOCK_MODE(LOCK_RUNTIME),
    .CLK_NS(PER), .ANALOG_NS(ANS), .DIGITAL_NS(DNS)) u0 (
    .clk(clk), .rst_n(rst_n), .reset_req(req0), .lock_in(lock0), .manual_sel(man0),
    .analog_rst(ana0), .digital_rst(dig0));
  rx_lane_reset_seq #(.LANES(3), .PER_LANE(1'b0), .ENABLE(1'b1), .LOCK_MODE(LOCK_AUTO),
    .CLK_NS(PER), .ANALOG_NS(ANS), .DIGITAL_NS(DNS)) u1 (
    .clk(clk), .rst_n(rst_n), .reset_req(req1), .lock_in(lock1), .manual_sel(1'b0),
    .analog_rst(ana1), .digital_rst(dig1));
  rx_lane_reset_seq #(.LANES(2), .PER_LANE(1'b0), .ENABLE(1'b1), .LOCK_MODE(LOCK_MANUAL),
    .CLK_NS(PER), .ANALOG_NS(ANS), .DIGITAL_NS(DNS)) u2 (
    .clk(clk), .rst_n(rst_n), .reset_req(req2), .lock_in(lock2), .manual_sel(1'b0),
    .analog_rst(ana2), .digital_rst(dig2));
  rx_lane_reset_seq #(.LANES(2), .PER_LANE(1'b1), .ENABLE(1'b0), .LOCK_MODE(LOCK_AUTO),
    .CLK_NS(PER), .ANALOG_NS(ANS), .DIGITAL_NS(DNS)) u3 (
    .clk(clk), .rst_n(rst_n), .reset_req(req3), .lock_in(lock3), .manual_sel(man3),
    .analog_rst(ana3), .digital_rst(dig3));

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  int A, D;

  // smallest whole cycle count that covers the duration
  function automatic int cover_cycles(input int ns);
    int c = 0;
    while (c * PER < ns) c++;
    if (c == 0) c = 1;
    return c;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic r1_quiet(input string where);
    check({"R1 disabled analog ", where}, ana3, 0);
    check({"R1 disabled digital ", where}, dig3, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    A = cover_cycles(ANS);
    D = cover_cycles(DNS);
    req0 = 2'b11; lock0 = 2'b11; man0 = 1'b0;
    req1 = 1'b1;  lock1 = 3'b111;
    req2 = 1'b1;  lock2 = 2'b11;
    req3 = 2'b11; lock3 = 2'b11; man3 = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(5);
    // R11: both resets held while requested
    check("R11 reset analog u0", ana0, 2'b11);
    check("R11 reset digital u0", dig0, 2'b11);
    check("R11 reset analog u1", ana1, 1);
    check("R11 reset digital u2", dig2, 1);
    r1_quiet("after reset");

    // R2 / R3: release timing on all enabled units
    req0 = 2'b00; req1 = 1'b0; req2 = 1'b0; req3 = 2'b00;
    step(A + 1);
    check("R2 analog still on u0", ana0, 2'b11);
    check("R2 analog still on u1", ana1, 1);
    step(1);
    check("R2 analog off u0", ana0, 2'b00);
    check("R2 analog off u1", ana1, 0);
    check("R2 analog off u2", ana2, 0);
    check("R3 digital still on u0", dig0, 2'b11);
    step(D);
    check("R3 digital still on at A+D+2 u1", dig1, 1);
    check("R3 digital still on at A+D+2 u0", dig0, 2'b11);
    step(1);
    check("R3 digital off u0", dig0, 2'b00);
    check("R3 digital off u1", dig1, 0);
    check("R3 digital off u2", dig2, 0);
    r1_quiet("after release");

    // R8 / R10: request on lane 1 only
    req0 = 2'b10;
    step(3);
    check("R10 request raises analog lane1", ana0, 2'b10);
    check("R8 lane0 untouched digital", dig0, 2'b10);
    req0 = 2'b00;
    step(A + D + 5);
    check("R8 lane1 released again", dig0, 2'b00);

    // R10: restart in the middle of the digital hold (u2)
    req2 = 1'b1; step(1); req2 = 1'b0; step(2);
    check("R10 pulse asserts analog", ana2, 1);
    step(A + 3);
    check("R10 in hold, analog off", ana2, 0);
    check("R10 in hold, digital on", dig2, 1);
    req2 = 1'b1; step(1); req2 = 1'b0; step(2);
    check("R10 second pulse asserts analog", ana2, 1);
    step(A);
    check("R10 analog off after restart", ana2, 0);
    step(D);
    check("R10 digital still on after full restart", dig2, 1);
    step(1);
    check("R10 digital off after restart", dig2, 0);

    // R5 / R9: exhaustive lock patterns on the shared auto controller
    for (int p = 0; p < 8; p++) begin
      lock1 = 3'(p);
      step(3);
      check($sformatf("R9 R5 digital for lock=%0d", p), dig1, (p != 7) ? 1 : 0);
      check($sformatf("R5 analog stays off lock=%0d", p), ana1, 0);
      lock1 = 3'b111;
      if (p != 7) begin
        step(D + 2);
        check($sformatf("R5 hold restarts lock=%0d", p), dig1, 1);
        step(1);
        check($sformatf("R5 released after relock lock=%0d", p), dig1, 0);
      end
    end

    // R6: manual mode ignores lock loss
    for (int p = 0; p < 3; p++) begin
      lock2 = 2'(p);
      step(10);
      check($sformatf("R6 manual lock=%0d digital", p), dig2, 0);
      lock2 = 2'b11;
      step(4);
    end

    // R4: hold waits for lock, even in manual mode
    lock2 = 2'b10;
    req2 = 1'b1; step(1); req2 = 1'b0;
    step(A + 2);
    check("R4 analog released without lock", ana2, 0);
    step(D + 10);
    check("R4 digital waits for lock", dig2, 1);
    lock2 = 2'b11;
    step(D + 2);
    check("R4 digital still on D+2 after lock", dig2, 1);
    step(1);
    check("R4 digital off D+3 after lock", dig2, 0);

    // R7: run-time selection on u0
    man0 = 1'b1; step(3);
    lock0 = 2'b00;
    step(10);
    check("R7 manual_sel=1 keeps running", dig0, 2'b00);
    man0 = 1'b0;
    step(3);
    check("R7 manual_sel=0 reasserts", dig0, 2'b11);
    lock0 = 2'b01;
    step(D + 3);
    check("R8 only locked lane releases", dig0, 2'b10);
    lock0 = 2'b11;
    step(D + 3);
    check("R8 both lanes released", dig0, 2'b00);

    // R1: disabled instance under toggling inputs
    req3 = 2'b11; lock3 = 2'b00; man3 = 1'b1;
    step(6);
    r1_quiet("after toggles");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule